// File: doc/BRIEF.md
# Four-Lane Neural Multiply-Accumulate Array

This block computes four neural-network accumulations in parallel. One 16-bit weight word is broadcast to all four lanes each cycle. Each lane takes its own 16-bit data word from a packed four-word input. Every lane has a pre-adder in front of a signed multiplier and a 40-bit accumulator.

A per-term operation select picks one of two products:
- **Scalar product:** the lane adds `x*w` to its sum. This serves perceptron layers.
- **Squared distance:** the pre-adder forms `x-w` and the multiplier squares it. This serves distance-based layers such as radial-basis or self-organising maps.

A new term can be offered on every cycle. A start flag begins a fresh accumulation, and a last flag marks the final term of a vector.

The product is registered in one pipeline stage, and the accumulator updates on the cycle after that. A term offered before clock edge N therefore shows up in the sums after edge N+1. When the final term of a vector has been absorbed, `result_valid` pulses for one cycle while `result_bus` carries the four 40-bit sums. The sums stay on `result_bus` until further terms change them.

Top module: `nmac_array4`

## Requirements
- R1: With `op_dist`=0, each lane's sum is the signed two's-complement sum of `data_in` lane word times `weight_in` over the terms of the vector.
- R2: With `op_dist`=1, each lane's sum is the sum over the terms of `(x - w)` squared, computed without overflow for any 16-bit operands.
- R3: The single `weight_in` word of a term is used by all four lanes. Lane g uses `data_in[16g+15:16g]`, and its sum appears on `result_bus[40g+39:40g]`.
- R4: `op_dist` is sampled with each term, so one vector may mix both operations.
- R5: A term with `in_valid`=1 and `start_vector`=1 replaces the previous sum with its own product instead of adding to it.
- R6: `start_vector`=1 with `in_valid`=0 sets all four sums to zero. The zero is visible two clock edges after the request.
- R7: `result_valid` is 1 exactly in the cycle that follows the second rising edge after a term with `in_valid`=1 and `last_element`=1. In every other cycle it is 0.
- R8: Without `in_valid` or `start_vector`, the data, weight, mode and last inputs have no effect: `result_bus` holds and `result_valid` stays 0.
- R9: While `rst_n` is low, `result_valid` is 0 and `result_bus` is all zeros.
- R10: Extreme operands give exact results in the 40-bit sums: -32768 times -32768, and the square of 32767 minus -32768.
- R11: Terms may arrive on consecutive cycles, including single-term vectors back to back, and each produces its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_dist | input | 1 | 0 = scalar product term, 1 = squared distance term |
| in_valid | input | 1 | A term is presented this cycle |
| start_vector | input | 1 | Begin a new accumulation (clears the sums) |
| last_element | input | 1 | This term is the last of the vector |
| weight_in | input | 16 | Shared weight word, two's complement |
| data_in | input | 64 | Four data words, lane g in bits 16g+15..16g |
| result_valid | output | 1 | One-cycle pulse: sums are final |
| result_bus | output | 160 | Four 40-bit sums, lane g in bits 40g+39..40g |

## Verification
The bench builds the block with its default parameters: four lanes, 16-bit operands and 40-bit sums. At these widths the full-scale corner products can be reached directly: the most negative value squared, and the largest possible difference squared. Both still fit exactly in the sums. Running four lanes at once against one broadcast weight means a swapped lane slice or a lane given the wrong weight shows up as a wrong sum in a specific lane. A continuous stream of terms with mixed operations and back-to-back single-term vectors exercises the two-stage timing of the flags against the data.

// File: rtl/nmac_pkg.sv
package nmac_pkg;
   typedef enum logic {
      OP_DOT  = 1'b0,
      OP_DIST = 1'b1
   } nmac_op_e;
endpackage

// File: rtl/nmac_prod.sv
// Pre-adder plus multiplier, one registered stage.
module nmac_prod #(
   parameter int DW = 16,
   parameter int PW = 2 * DW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  nmac_pkg::nmac_op_e   op,
   input  logic [DW-1:0]        x,
   input  logic [DW-1:0]        w,
   output logic signed [PW-1:0] prod
);
   localparam int EW = DW + 1;

   logic signed [EW-1:0] xe, we, diff, opa, opb;
   logic signed [PW-1:0] prod_c;

   always_comb begin
      xe   = EW'($signed(x));
      we   = EW'($signed(w));
      diff = xe - we;
      if (op == nmac_pkg::OP_DIST) begin
         opa = diff;
         opb = diff;
      end else begin
         opa = xe;
         opb = we;
      end
      prod_c = PW'(opa) * PW'(opb);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prod <= '0;
      else if (en) prod <= prod_c;
   end
endmodule

// File: rtl/nmac_accum.sv
// Accumulating adder with load-on-clear.
module nmac_accum #(
   parameter int PW = 34,
   parameter int AW = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 add_en,
   input  logic signed [PW-1:0] prod,
   output logic [AW-1:0]        acc
);
   logic [AW-1:0] prod_ext;
   assign prod_ext = AW'(prod);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (clr)    acc <= add_en ? prod_ext : '0;
      else if (add_en) acc <= acc + prod_ext;
   end
endmodule

// File: rtl/nmac_ctrl.sv
// Flag pipeline shared by all lanes.
module nmac_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic start_vector,
   input  logic last_element,
   output logic s1_valid,
   output logic s1_clr,
   output logic result_valid
);
   logic s1_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid     <= 1'b0;
         s1_clr       <= 1'b0;
         s1_last      <= 1'b0;
         result_valid <= 1'b0;
      end else begin
         s1_valid     <= in_valid;
         s1_clr       <= start_vector;
         s1_last      <= in_valid & last_element;
         result_valid <= s1_valid & s1_last;
      end
   end
endmodule

// File: rtl/nmac_array4.sv
module nmac_array4 #(
   parameter int LANES = 4,
   parameter int DW    = 16,
   parameter int AW    = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_dist,
   input  logic                in_valid,
   input  logic                start_vector,
   input  logic                last_element,
   input  logic [DW-1:0]       weight_in,
   input  logic [LANES*DW-1:0] data_in,
   output logic                result_valid,
   output logic [LANES*AW-1:0] result_bus
);
   localparam int PW = 2 * DW + 2;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("nmac_array4: LANES must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("nmac_array4: DW must be at least 2");
      end
      if (AW < PW) begin : g_bad_aw
         $error("nmac_array4: AW must hold one full product");
      end
   endgenerate

   nmac_pkg::nmac_op_e op;
   logic s1_valid, s1_clr;

   assign op = nmac_pkg::nmac_op_e'(op_dist);

   nmac_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .start_vector (start_vector),
      .last_element (last_element),
      .s1_valid     (s1_valid),
      .s1_clr       (s1_clr),
      .result_valid (result_valid)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [PW-1:0] prod;

      nmac_prod #(.DW(DW), .PW(PW)) u_prod (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (in_valid),
         .op    (op),
         .x     (data_in[g*DW +: DW]),
         .w     (weight_in),
         .prod  (prod)
      );

      nmac_accum #(.PW(PW), .AW(AW)) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (s1_clr),
         .add_en (s1_valid),
         .prod   (prod),
         .acc    (result_bus[g*AW +: AW])
      );
   end
endmodule

// File: rtl/nmac_array4_chk.sv
module nmac_array4_chk #(
   parameter int LANES = 4,
   parameter int AW    = 40
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_dist,
   input logic                in_valid,
   input logic                start_vector,
   input logic                last_element,
   input logic                result_valid,
   input logic [LANES*AW-1:0] result_bus
);
   logic [1:0]       age;
   logic             ok;
   logic [LANES-1:0] msbs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 3) age <= age + 2'd1;
   end
   assign ok = (age == 2'd3);

   always_comb begin
      for (int i = 0; i < LANES; i++) msbs[i] = result_bus[i*AW + AW - 1];
   end

   // R7
   valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && $past(in_valid && last_element, 2)) |-> result_valid);

   // R7
   valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && result_valid) |-> $past(in_valid && last_element, 2));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !$past(in_valid, 2) && !$past(start_vector, 2)) |-> $stable(result_bus));

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && $past(start_vector && !in_valid, 2)) |-> (result_bus == '0));

   // R2
   dist_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && result_valid && $past(in_valid && start_vector && op_dist, 2))
      |-> ($countones(msbs) == 0));
endmodule

bind nmac_array4 nmac_array4_chk #(.LANES(LANES), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_dist      (op_dist),
   .in_valid     (in_valid),
   .start_vector (start_vector),
   .last_element (last_element),
   .result_valid (result_valid),
   .result_bus   (result_bus)
);

// File: tb/nmac_array4_test.sv
`timescale 1ns/1ps
module nmac_array4_test;
   localparam int LANES = 4;
   localparam int DW    = 16;
   localparam int AW    = 40;

   typedef struct packed {
      logic [3:0]  req;
      logic        op;
      logic        st;
      logic        ls;
      logic [15:0] w;
      logic [63:0] x;
   } term_t;

   localparam int NT = 13;
   localparam term_t TBL [NT] = '{
      '{4'd1,  1'b0, 1'b1, 1'b0, 16'h0003, 64'h0001_FFFF_0010_8000},
      '{4'd1,  1'b0, 1'b0, 1'b0, 16'hFFFE, 64'h0005_0007_7FFF_0002},
      '{4'd1,  1'b0, 1'b0, 1'b1, 16'h0100, 64'hFFF0_0003_0000_0001},
      '{4'd5,  1'b1, 1'b1, 1'b1, 16'h0005, 64'h0005_0000_FFFB_8000},
      '{4'd2,  1'b1, 1'b1, 1'b0, 16'h8000, 64'h7FFF_7FFF_0000_8000},
      '{4'd2,  1'b1, 1'b0, 1'b0, 16'h7FFF, 64'h8000_8000_7FFF_0001},
      '{4'd2,  1'b1, 1'b0, 1'b1, 16'h0010, 64'h0011_000F_0000_FFFF},
      '{4'd4,  1'b0, 1'b1, 1'b0, 16'h8000, 64'h8000_7FFF_0001_0000},
      '{4'd4,  1'b1, 1'b0, 1'b1, 16'h0001, 64'h0001_8000_0003_FFFF},
      '{4'd11, 1'b0, 1'b1, 1'b1, 16'h1234, 64'h0001_0002_FFFF_0000},
      '{4'd11, 1'b1, 1'b1, 1'b1, 16'h0000, 64'h0003_FFFD_0100_8000},
      '{4'd3,  1'b0, 1'b1, 1'b1, 16'h0007, 64'h0001_0002_0003_0004},
      '{4'd10, 1'b0, 1'b1, 1'b1, 16'h8000, 64'h8000_8000_7FFF_8000}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                op_dist = 1'b0, in_valid = 1'b0;
   logic                start_vector = 1'b0, last_element = 1'b0;
   logic [DW-1:0]       weight_in = '0;
   logic [LANES*DW-1:0] data_in = '0;
   logic                result_valid;
   logic [LANES*AW-1:0] result_bus;

   int checks = 0, failures = 0;
   longint model [LANES];
   longint hist  [NT][LANES];

   always #2.5 clk = ~clk;

   nmac_array4 uut (
      .clk(clk), .rst_n(rst_n), .op_dist(op_dist), .in_valid(in_valid),
      .start_vector(start_vector), .last_element(last_element),
      .weight_in(weight_in), .data_in(data_in),
      .result_valid(result_valid), .result_bus(result_bus)
   );

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd1:  return "R1";
         4'd2:  return "R2";
         4'd3:  return "R3";
         4'd4:  return "R4";
         4'd5:  return "R5";
         4'd10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic op, input logic iv, input logic st, input logic ls,
                        input logic [15:0] w, input logic [63:0] x);
      op_dist = op; in_valid = iv; start_vector = st; last_element = ls;
      weight_in = w; data_in = x;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [AW-1:0] snap;
      for (int l = 0; l < LANES; l++) model[l] = 0;

      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9", AW'(result_valid), '0);
      check("R9", result_bus[AW-1:0], '0);
      check("R9", result_bus[LANES*AW-1 -: AW], '0);
      rst_n = 1'b1;

      // vector table, one term per cycle
      for (int i = 0; i < NT + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            int k = i - 2;
            check("R7", AW'(result_valid), AW'(TBL[k].ls));
            if (TBL[k].ls) begin
               for (int l = 0; l < LANES; l++)
                  check(tag(TBL[k].req), result_bus[l*AW +: AW], AW'(hist[k][l]));
            end
         end
         if (i < NT) begin
            term_t t = TBL[i];
            drive(t.op, 1'b1, t.st, t.ls, t.w, t.x);
            for (int l = 0; l < LANES; l++) begin
               longint xv = longint'($signed(t.x[l*16 +: 16]));
               longint wv = longint'($signed(t.w));
               longint p  = t.op ? (xv - wv) * (xv - wv) : xv * wv;
               model[l] = t.st ? p : model[l] + p;
               hist[i][l] = model[l];
            end
         end else begin
            drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
         end
      end

      // R8: inputs without in_valid or start are ignored
      snap = result_bus[AW +: AW];
      for (int c = 0; c < 4; c++) begin
         drive(c[0], 1'b0, 1'b0, 1'b1, 16'h5A5A ^ 16'(c), 64'hDEAD_BEEF_0BAD_F00D);
         @(negedge clk);
      end
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
      check("R8", AW'(result_valid), '0);
      check("R8", result_bus[AW +: AW], snap);

      // R6: start alone clears all sums
      drive(1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
      for (int l = 0; l < LANES; l++) check("R6", result_bus[l*AW +: AW], '0);
      check("R6", AW'(result_valid), '0);

      // R7: single-cycle pulse and timing
      drive(1'b0, 1'b1, 1'b1, 1'b1, 16'h0002, 64'h0003_0003_0003_0003);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
      check("R7", AW'(result_valid), '0);
      @(negedge clk);
      check("R7", AW'(result_valid), 1);
      check("R7", result_bus[3*AW +: AW], 40'd6);
      @(negedge clk);
      check("R7", AW'(result_valid), '0);

      // R9: reset in mid-run clears sums
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", result_bus[3*AW +: AW], '0);
      check("R9", AW'(result_valid), '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule